// File: doc/BRIEF.md
# Two-Channel Prescaled Interval Timer

This block holds two 16-bit timer channels. Both run from one functional clock, and each channel has its own power-of-two prescaler. Software reaches each channel through a window of four 16-bit registers on a simple read/write bus:

- a control word,
- an event status word,
- a target (load) value,
- a live count.

Once enabled, a channel's counter starts at zero and advances on every prescaled tick. When the next value would equal the target, the channel records an event.

- In auto-reload mode the count falls back to zero and keeps running. With a target of 0xFFFF this makes the channel a free-running up-counter that can be read at any time.
- In one-shot mode the count parks at the target and the hardware clears the channel's enable bit.

Each channel drives its own interrupt line. The line is the event flag gated by an interrupt-enable bit. The flag stays set until software writes a one to it.

Top module: `gp_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and both interrupt lines are low.
- R2: Channel x (x = 0, 1) decodes its registers at byte addresses 0x80*(x+1) plus an offset: control at +0x0, status at +0x4, load at +0x8, count at +0xC. In the control word, bit 8 is interrupt enable, bit 5 is run enable, bit 4 is one-shot (1) or auto-reload (0), and bits [3:0] are the prescaler code. All other control bits read back 0.
- R3: With prescaler code n, the count advances once every 2^n clocks. The first advance falls 2^n clocks after the write that sets run enable. Codes 8 to 15 all divide by 256.
- R4: In auto-reload mode, a tick that would bring the count to the load value sets the status flag (status bit 0) and returns the count to 0. With load 0xFFFF the channel counts freely from 0.
- R5: In one-shot mode, the matching tick sets the flag and leaves the count equal to the load value. It also clears run enable, which reads back 0, and the count then stays put.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a matching tick and a clearing write fall in the same clock, the flag stays set.
- R7: A channel's interrupt output is high exactly when its flag and its interrupt enable are both set. Clearing interrupt enable does not clear the flag.
- R8: Clearing run enable freezes the count. Setting it again resumes counting from the frozen value.
- R9: A write to the load register sets the count to 0 and restarts the prescaler, so the next event falls a full load period later.
- R10: Reads of unmapped offsets, and of windows with no channel, return 0. Writes to the count register are ignored.
- R11: The two channels count independently, each with its own prescaler, mode and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by both channels |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte address of the accessed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read access |
| irq | output | 2 | Per-channel interrupt, bit x belongs to channel x |

## Verification
A prescaler that is off by a cycle, or that restarts at the wrong moment, shows at once in the live count. The count drifts from the expected value of ticks elapsed since the enable edge, and the bench reads it at exact cycle offsets from that edge. A wrong match or mode decision shows within one tick of the target: the count fails to return to zero or to park, the run-enable bit fails to drop, or the status flag and interrupt line disagree with the target crossing. Random targets, modes and codes then spread these checks over many cycle offsets, including the cycles just before and just after an event.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

    localparam int DATA_W   = 16;
    localparam int CODE_W   = 4;
    localparam int PSC_MAX  = 8;
    localparam int PSC_W    = PSC_MAX;
    localparam int WIN_SH   = 7;

    localparam logic [WIN_SH-1:0] OFF_CTRL  = 7'h00;
    localparam logic [WIN_SH-1:0] OFF_STAT  = 7'h04;
    localparam logic [WIN_SH-1:0] OFF_LOAD  = 7'h08;
    localparam logic [WIN_SH-1:0] OFF_COUNT = 7'h0C;

    localparam int BIT_IE   = 8;
    localparam int BIT_RUN  = 5;
    localparam int BIT_ONE  = 4;

    typedef struct packed {
        logic              irq_en;
        logic              run;
        logic              one_shot;
        logic [CODE_W-1:0] code;
    } chan_ctrl_t;

    function automatic chan_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        chan_ctrl_t c;
        c.irq_en   = w[BIT_IE];
        c.run      = w[BIT_RUN];
        c.one_shot = w[BIT_ONE];
        c.code     = w[CODE_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input chan_ctrl_t c);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[BIT_IE]     = c.irq_en;
        w[BIT_RUN]    = c.run;
        w[BIT_ONE]    = c.one_shot;
        w[CODE_W-1:0] = c.code;
        return w;
    endfunction

    function automatic logic [PSC_W-1:0] psc_mask(input logic [CODE_W-1:0] code);
        if (int'(code) >= PSC_MAX) begin
            return '1;
        end
        return PSC_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/gp_timer_prescaler.sv
module gp_timer_prescaler
    import gp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] mask;

    assign mask = psc_mask(code);
    assign tick = run && !restart && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/gp_timer_channel.sv
module gp_timer_channel
    import gp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  chan_ctrl_t        ctrl_in,
    input  logic              clr_we,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_in,
    output chan_ctrl_t        ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] count_q,
    output logic              irq
);

    logic              tick;
    logic              hit;
    logic [DATA_W-1:0] count_nxt;

    gp_timer_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (load_we),
        .code    (ctrl_q.code),
        .tick    (tick)
    );

    assign count_nxt = count_q + 1'b1;
    assign hit       = tick && (count_nxt == load_q);
    assign irq       = flag_q && ctrl_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_in;
        end else if (hit && ctrl_q.one_shot) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
        end else if (load_we) begin
            load_q <= load_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load_we) begin
            count_q <= '0;
        end else if (hit) begin
            count_q <= ctrl_q.one_shot ? load_q : '0;
        end else if (tick) begin
            count_q <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_we) begin
            flag_q <= 1'b0;
        end
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !hit) |=> (count_q == $past(count_q) + 1'b1));  // R3

    AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (hit && !ctrl_q.one_shot) |=> (count_q == '0 && flag_q));  // R4

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
        (hit && ctrl_q.one_shot && !ctrl_we) |=> (!ctrl_q.run && count_q == load_q));  // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_we) |=> flag_q);  // R6

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !load_we) |=> $stable(count_q));  // R8

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (count_q == '0));  // R9

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gp_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int IDX_W = ADDR_W - WIN_SH;

    logic [IDX_W-1:0]  win_idx;
    logic [WIN_SH-1:0] win_off;
    logic              wr_req;
    logic              rd_req;

    chan_ctrl_t        ch_ctrl  [NUM_CH];
    logic              ch_flag  [NUM_CH];
    logic [DATA_W-1:0] ch_load  [NUM_CH];
    logic [DATA_W-1:0] ch_count [NUM_CH];

    assign win_idx = bus_addr[ADDR_W-1:WIN_SH];
    assign win_off = bus_addr[WIN_SH-1:0];
    assign wr_req  = bus_sel && bus_wr;
    assign rd_req  = bus_sel && !bus_wr;

    for (genvar x = 0; x < NUM_CH; x++) begin : g_ch
        logic win_hit;
        assign win_hit = (win_idx == IDX_W'(x + 1));

        gp_timer_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (wr_req && win_hit && win_off == OFF_CTRL),
            .ctrl_in (ctrl_from_word(bus_wdata)),
            .clr_we  (wr_req && win_hit && win_off == OFF_STAT && bus_wdata[0]),
            .load_we (wr_req && win_hit && win_off == OFF_LOAD),
            .load_in (bus_wdata),
            .ctrl_q  (ch_ctrl[x]),
            .flag_q  (ch_flag[x]),
            .load_q  (ch_load[x]),
            .count_q (ch_count[x]),
            .irq     (irq[x])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int x = 0; x < NUM_CH; x++) begin
            if (rd_req && win_idx == IDX_W'(x + 1)) begin
                case (win_off)
                    OFF_CTRL:  bus_rdata = ctrl_to_word(ch_ctrl[x]);
                    OFF_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, ch_flag[x]};
                    OFF_LOAD:  bus_rdata = ch_load[x];
                    OFF_COUNT: bus_rdata = ch_count[x];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> (bus_rdata == '0));  // R10

endmodule

// File: tb/gp_timer_bench.sv
`timescale 1ns/1ps
module gp_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel;
    logic        wr;
    logic [9:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gp_timer u_gp_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    function automatic logic [9:0] ra(input int ch, input int off);
        return 10'((ch + 1) * 128 + off);
    endfunction

    function automatic logic [15:0] exp_count(input int ticks, input int ld, input bit os);
        if (os) return 16'((ticks >= ld) ? ld : ticks);
        return 16'(ticks % ld);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr16(input logic [9:0] a, input logic [15:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd16(input logic [9:0] a, output logic [15:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic adv(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic start(input int ch, input int code, input int ld, input bit os, input bit ie);
        wr16(ra(ch, 0), 16'h0000);
        wr16(ra(ch, 4), 16'h0001);
        wr16(ra(ch, 8), 16'(ld));
        wr16(ra(ch, 0), 16'((int'(ie) << 8) | (1 << 5) | (int'(os) << 4) | code));
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd7321));
        rst = 1'b1; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        adv(1);

        for (int ch = 0; ch < 2; ch++) begin
            for (int off = 0; off < 16; off += 4) begin
                rd16(ra(ch, off), v);
                chk("R1 reset register", v, 16'h0);
            end
        end
        chk("R1 reset irq", {14'h0, irq}, 16'h0);

        // Auto-reload, /1, target 5, interrupt enabled
        start(0, 0, 5, 1'b0, 1'b1);
        adv(3);
        rd16(ra(0, 12), v); chk("R3 count /1 after 3", v, 16'd3);
        rd16(ra(0, 4), v);  chk("R4 flag before match", v, 16'd0);
        adv(2);
        rd16(ra(0, 12), v); chk("R4 count wraps to 0", v, 16'd0);
        rd16(ra(0, 4), v);  chk("R4 flag at match", v, 16'd1);
        chk("R7 irq with enable", {15'h0, irq[0]}, 16'd1);
        adv(4);
        // next match falls on the write edge: set must win over clear
        wr16(ra(0, 4), 16'h0001);
        rd16(ra(0, 4), v);  chk("R6 set wins over clear", v, 16'd1);
        wr16(ra(0, 4), 16'h0000);
        rd16(ra(0, 4), v);  chk("R6 write 0 keeps flag", v, 16'd1);
        wr16(ra(0, 4), 16'h0001);
        rd16(ra(0, 4), v);  chk("R6 write 1 clears", v, 16'd0);
        chk("R7 irq low after clear", {15'h0, irq[0]}, 16'd0);

        // One-shot, /4, target 3
        start(1, 2, 3, 1'b1, 1'b0);
        adv(11);
        rd16(ra(1, 4), v);  chk("R5 no flag one cycle early", v, 16'd0);
        adv(1);
        rd16(ra(1, 4), v);  chk("R5 flag at expiry", v, 16'd1);
        rd16(ra(1, 12), v); chk("R5 count parks at load", v, 16'd3);
        rd16(ra(1, 0), v);  chk("R5 run bit cleared", v, 16'h0012);
        chk("R7 irq masked", {15'h0, irq[1]}, 16'd0);
        adv(20);
        rd16(ra(1, 12), v); chk("R5 count stays", v, 16'd3);
        wr16(ra(1, 0), 16'h0112);
        chk("R7 irq when enabled", {15'h0, irq[1]}, 16'd1);
        wr16(ra(1, 0), 16'h0012);
        chk("R7 irq off", {15'h0, irq[1]}, 16'd0);
        rd16(ra(1, 4), v);  chk("R7 flag kept after ie clear", v, 16'd1);

        // Freeze and resume
        start(0, 0, 1000, 1'b0, 1'b0);
        adv(10);
        wr16(ra(0, 0), 16'h0000);
        adv(20);
        rd16(ra(0, 12), v); chk("R8 frozen count", v, 16'd11);
        wr16(ra(0, 0), 16'h0020);
        adv(5);
        rd16(ra(0, 12), v); chk("R8 resumed count", v, 16'd16);

        // Load rewrite while running
        wr16(ra(0, 8), 16'd500);
        adv(7);
        rd16(ra(0, 12), v); chk("R9 count restarted", v, 16'd7);
        wr16(ra(0, 0), 16'h0000);
        wr16(ra(0, 12), 16'h1234);
        rd16(ra(0, 12), v); chk("R10 count write ignored", v, 16'd8);

        // Codes above 8 divide by 256
        start(0, 12, 2, 1'b0, 1'b0);
        adv(511);
        rd16(ra(0, 12), v); chk("R3 code 12 count", v, 16'd1);
        rd16(ra(0, 4), v);  chk("R3 code 12 no flag yet", v, 16'd0);
        adv(1);
        rd16(ra(0, 4), v);  chk("R3 code 12 flag", v, 16'd1);

        // Free-running with full-scale target
        start(0, 0, 16'hFFFF, 1'b0, 1'b0);
        adv(1000);
        rd16(ra(0, 12), v); chk("R4 free-run count", v, 16'd1000);

        // Independence of channels
        start(0, 1, 100, 1'b0, 1'b0);
        start(1, 3, 100, 1'b0, 1'b0);
        adv(40);
        rd16(ra(0, 12), v); chk("R11 channel 0 count", v, 16'd22);
        rd16(ra(1, 12), v); chk("R11 channel 1 count", v, 16'd5);

        // Unmapped reads and reserved control bits
        wr16(ra(1, 0), 16'hFECF);
        rd16(ra(1, 0), v);  chk("R2 reserved ctrl bits", v, 16'h000F);
        rd16(ra(0, 16), v); chk("R10 unmapped offset", v, 16'h0);
        rd16(ra(2, 0), v);  chk("R10 empty window", v, 16'h0);
        rd16(10'h004, v);   chk("R10 below first window", v, 16'h0);
        rd16(ra(1, 8), v);  chk("R2 load readback", v, 16'd100);

        // Random trials
        for (int t = 0; t < 24; t++) begin
            int ch   = int'($urandom % 2);
            int code = int'($urandom % 4);
            int ld   = 3 + int'($urandom % 30);
            bit os   = 1'($urandom % 2);
            int k    = 1 + int'($urandom % ((3 * ld) << code));
            int tk;
            start(ch, code, ld, os, 1'b1);
            adv(k);
            tk = k >> code;
            rd16(ra(ch, 12), v);
            chk(os ? "R5 random count" : "R4 random count", v, exp_count(tk, ld, os));
            rd16(ra(ch, 4), v);
            chk("R6 random flag", v, 16'(tk >= ld));
            chk("R7 random irq", {15'h0, irq[ch]}, 16'(tk >= ld));
            rd16(ra(ch, 0), v);
            chk("R2 random ctrl", v,
                16'((1 << 8) | (int'(!(os && tk >= ld)) << 5) | (int'(os) << 4) | code));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule